// File: doc/BRIEF.md
# SPI Peripheral Pad Multiplexer with GPIO

This block sits between the register file of an SPI-slave peripheral and its pads. Two byte-wide registers set, for each of four shared pads (interrupt, serial read data, clock output and amplifier control), whether the pad carries its normal function or acts as a general-purpose pin. They also set whether the pad drives both levels or only pulls low, the active level of the interrupt, and whether the serial link uses separate data-in and data-out pads or one shared bidirectional data pad. Each pad is modelled as an output value, an output enable and an input level. The block never drives analog levels.

The interrupt can be moved off its own pad. It then appears on the data-in pad, but only while the slave select is idle (high). This frees the interrupt pad for general use. In shared-data mode the data-in pad turns bidirectional: it carries read data whenever the SPI core enables its output. The read-data pad is then free for general use. Software reads the pad levels through a synchronizer. The same reads return the stored output bits.

Top module: `spi_padmux`

## Requirements
- R1: After reset the configuration register (address 0x0D) reads 0x00 and bits 7..4 of the GPIO register (address 0x0E) read 0. With no interrupt pending, the interrupt pad then drives high with its output enable set.
- R2: A write to 0x0D stores all eight bits and reads back unchanged. A write to 0x0E stores only bits 7..4. A write to any other address changes nothing, and reads of other addresses return 0x00.
- R3: The configuration bits are: bit 7 interrupt pull-low-only, bit 6 interrupt active-high, bit 5 read-data pull-low-only, bit 4 clock-out pull-low-only, bit 3 amplifier-control pull-low-only, bit 2 amplifier-control as GPIO, bit 1 shared-data mode, bit 0 interrupt as GPIO. With bit 0 clear, the interrupt pad shows `irq_req` at the level chosen by bit 6 (bit 6 = 0 means active low).
- R4: A pad with its pull-low-only bit set drives `o`=0 with `oe`=1 when its value is 0, and drops `oe` when its value is 1. With the bit clear, the pad drives its value with `oe`=1, unless its function disables the output.
- R5: With configuration bit 0 set, the interrupt pad follows GPIO bit 4. The interrupt level chosen by bit 6 is driven on the data-in pad while `spi_ss_n` is 1. The data-in pad output enable is 0 while `spi_ss_n` is 0 and shared-data mode is off.
- R6: With configuration bit 1 clear, the data-in pad is input only and its level is passed to `spi_sdi`. The read-data pad carries `spi_sdo`, enabled by `spi_sdo_oe` and shaped by configuration bit 5.
- R7: With configuration bit 1 set, the data-in pad drives `spi_sdo` with `oe` = `spi_sdo_oe`. The read-data pad follows GPIO bit 6.
- R8: With configuration bit 2 clear, the amplifier-control pad carries `pactl_fn`. With it set, the pad follows GPIO bit 5.
- R9: The clock-out pad is always a GPIO and follows GPIO bit 7.
- R10: GPIO register bits 3..0 return the levels of the clock-out, read-data, amplifier-control and interrupt pad inputs, in that order. Each level passes through a two-flop synchronizer: a change shows on a read after the second rising clock edge and not after the first.
- R11: A write to the output bit of a pad that is in its function mode is stored but leaves the pad unchanged. The stored value takes effect once the pad is switched to GPIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_req | input | 1 | Internal interrupt state, 1 = pending |
| pactl_fn | input | 1 | Amplifier-control level from the radio core |
| spi_sdo | input | 1 | Serial read data from the SPI core |
| spi_sdo_oe | input | 1 | SPI core output enable for read data |
| spi_ss_n | input | 1 | Slave select, low = active |
| spi_sdi | output | 1 | Serial write data to the SPI core |
| irq_o | output | 1 | Interrupt pad output value |
| irq_oe | output | 1 | Interrupt pad output enable |
| irq_i | input | 1 | Interrupt pad input level |
| miso_o | output | 1 | Read-data pad output value |
| miso_oe | output | 1 | Read-data pad output enable |
| miso_i | input | 1 | Read-data pad input level |
| xout_o | output | 1 | Clock-out pad output value |
| xout_oe | output | 1 | Clock-out pad output enable |
| xout_i | input | 1 | Clock-out pad input level |
| pactl_o | output | 1 | Amplifier-control pad output value |
| pactl_oe | output | 1 | Amplifier-control pad output enable |
| pactl_i | input | 1 | Amplifier-control pad input level |
| mosi_o | output | 1 | Data-in / shared data pad output value |
| mosi_oe | output | 1 | Data-in / shared data pad output enable |
| mosi_i | input | 1 | Data-in / shared data pad input level |

## Verification
The assertions assume that the register port is only written with `reg_we` held for single cycles, and that the SPI core inputs are steady and free of X whenever the clock samples. The pad inputs may change at any time, because they reach the registers only through the synchronizer. The stimulus changes every input just after a falling clock edge and keeps all pad inputs at 0 outside the synchronizer test, so that each GPIO register read has a known value. The SPI core inputs are set to plain combinations, never toggled mid-cycle.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
   // configuration register layout, MSB first (bit 7 .. bit 0)
   typedef struct packed {
      logic irq_od;
      logic irq_hi;
      logic miso_od;
      logic xout_od;
      logic pactl_od;
      logic pactl_gp;
      logic three_wire;
      logic irq_gp;
   } cfg_t;

   localparam int NPAD      = 4;
   // pad index == bit position in the GPIO register nibbles
   localparam int PAD_IRQ   = 0;
   localparam int PAD_PACTL = 1;
   localparam int PAD_MISO  = 2;
   localparam int PAD_XOUT  = 3;
endpackage

// File: rtl/padmux_sync.sv
module padmux_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("padmux_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/padmux_drv.sv
module padmux_drv (
   input  logic use_fn,
   input  logic fn_val,
   input  logic fn_en,
   input  logic gp_val,
   input  logic od,
   output logic o,
   output logic oe
);
   logic val;
   logic en;

   always_comb begin
      val = use_fn ? fn_val : gp_val;
      en  = use_fn ? fn_en  : 1'b1;
      if (od) begin
         o  = 1'b0;
         oe = en & ~val;
      end else begin
         o  = val;
         oe = en;
      end
   end
endmodule

// File: rtl/padmux_regs.sv
module padmux_regs
   import padmux_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter int          N         = NPAD,
   parameter logic [7:0]  CFG_ADDR  = 8'h0D,
   parameter logic [7:0]  GPIO_ADDR = 8'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   input  logic [N-1:0]      pad_sync,
   output cfg_t              cfg,
   output logic [N-1:0]      gpio_out,
   output logic [DATA_W-1:0] rdata
);
   localparam int CFG_W = $bits(cfg_t);

   generate
      if (DATA_W != CFG_W || DATA_W != 2 * N) begin : g_bad_width
         $error("padmux_regs: data width must match the register layout");
      end
      if (CFG_ADDR == GPIO_ADDR) begin : g_bad_addr
         $error("padmux_regs: register addresses must differ");
      end
   endgenerate

   logic hit_cfg;
   logic hit_gpio;
   assign hit_cfg  = (addr == ADDR_W'(CFG_ADDR));
   assign hit_gpio = (addr == ADDR_W'(GPIO_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '0;
         gpio_out <= '0;
      end else if (we) begin
         if (hit_cfg)  cfg      <= cfg_t'(wdata);
         if (hit_gpio) gpio_out <= wdata[DATA_W-1 -: N];
      end
   end

   always_comb begin
      if (hit_cfg)       rdata = DATA_W'(cfg);
      else if (hit_gpio) rdata = {gpio_out, pad_sync};
      else               rdata = '0;
   end

   // R2: a GPIO write keeps exactly the upper nibble
   a_r2_gpio_store: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hit_gpio) |=> (gpio_out == $past(wdata[DATA_W-1 -: N])));
   // R2: writes to other addresses leave the configuration alone
   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(we && hit_cfg)) |=> $stable(cfg));
endmodule

// File: rtl/spi_padmux.sv
module spi_padmux
   import padmux_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] CFG_ADDR    = 8'h0D,
   parameter logic [7:0] GPIO_ADDR   = 8'h0E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   input  logic       reg_we,
   output logic [7:0] reg_rdata,
   input  logic       irq_req,
   input  logic       pactl_fn,
   input  logic       spi_sdo,
   input  logic       spi_sdo_oe,
   input  logic       spi_ss_n,
   output logic       spi_sdi,
   output logic       irq_o,
   output logic       irq_oe,
   input  logic       irq_i,
   output logic       miso_o,
   output logic       miso_oe,
   input  logic       miso_i,
   output logic       xout_o,
   output logic       xout_oe,
   input  logic       xout_i,
   output logic       pactl_o,
   output logic       pactl_oe,
   input  logic       pactl_i,
   output logic       mosi_o,
   output logic       mosi_oe,
   input  logic       mosi_i
);
   cfg_t            cfg;
   logic [NPAD-1:0] gpio_out;
   logic [NPAD-1:0] pad_in;
   logic [NPAD-1:0] pad_sync;
   logic [NPAD-1:0] use_fn, fn_val, fn_en, od;
   logic [NPAD-1:0] pad_o, pad_oe;
   logic            irq_level;

   padmux_regs #(
      .ADDR_W(8), .DATA_W(8), .N(NPAD),
      .CFG_ADDR(CFG_ADDR), .GPIO_ADDR(GPIO_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .we(reg_we), .pad_sync(pad_sync), .cfg(cfg), .gpio_out(gpio_out),
      .rdata(reg_rdata)
   );

   assign pad_in[PAD_IRQ]   = irq_i;
   assign pad_in[PAD_PACTL] = pactl_i;
   assign pad_in[PAD_MISO]  = miso_i;
   assign pad_in[PAD_XOUT]  = xout_i;

   padmux_sync #(.W(NPAD), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_sync)
   );

   assign irq_level = cfg.irq_hi ? irq_req : ~irq_req;

   always_comb begin
      use_fn[PAD_IRQ]   = ~cfg.irq_gp;
      fn_val[PAD_IRQ]   = irq_level;
      fn_en[PAD_IRQ]    = 1'b1;
      od[PAD_IRQ]       = cfg.irq_od;

      use_fn[PAD_PACTL] = ~cfg.pactl_gp;
      fn_val[PAD_PACTL] = pactl_fn;
      fn_en[PAD_PACTL]  = 1'b1;
      od[PAD_PACTL]     = cfg.pactl_od;

      use_fn[PAD_MISO]  = ~cfg.three_wire;
      fn_val[PAD_MISO]  = spi_sdo;
      fn_en[PAD_MISO]   = spi_sdo_oe;
      od[PAD_MISO]      = cfg.miso_od;

      use_fn[PAD_XOUT]  = 1'b0;
      fn_val[PAD_XOUT]  = 1'b0;
      fn_en[PAD_XOUT]   = 1'b0;
      od[PAD_XOUT]      = cfg.xout_od;
   end

   generate
      for (genvar p = 0; p < NPAD; p++) begin : g_pad
         padmux_drv u_drv (
            .use_fn(use_fn[p]), .fn_val(fn_val[p]), .fn_en(fn_en[p]),
            .gp_val(gpio_out[p]), .od(od[p]),
            .o(pad_o[p]), .oe(pad_oe[p])
         );
      end
   endgenerate

   assign irq_o    = pad_o[PAD_IRQ];
   assign irq_oe   = pad_oe[PAD_IRQ];
   assign pactl_o  = pad_o[PAD_PACTL];
   assign pactl_oe = pad_oe[PAD_PACTL];
   assign miso_o   = pad_o[PAD_MISO];
   assign miso_oe  = pad_oe[PAD_MISO];
   assign xout_o   = pad_o[PAD_XOUT];
   assign xout_oe  = pad_oe[PAD_XOUT];

   // data-in / shared data pad: core read data first, rerouted interrupt next
   always_comb begin
      if (cfg.three_wire && spi_sdo_oe) begin
         mosi_o  = spi_sdo;
         mosi_oe = 1'b1;
      end else if (cfg.irq_gp && spi_ss_n) begin
         mosi_o  = irq_level;
         mosi_oe = 1'b1;
      end else begin
         mosi_o  = 1'b0;
         mosi_oe = 1'b0;
      end
   end

   assign spi_sdi = mosi_i;

   // R4: a pull-low-only pad never drives a 1
   a_r4_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg.irq_od && irq_oe) |-> !irq_o) and
      ((cfg.miso_od && miso_oe) |-> !miso_o) and
      ((cfg.xout_od && xout_oe) |-> !xout_o) and
      ((cfg.pactl_od && pactl_oe) |-> !pactl_o));
   // R5: the data-in pad goes quiet while the slave is selected (4-wire)
   a_r5_mosi_quiet_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_ss_n && !cfg.three_wire) |-> !mosi_oe);
   // R6: 4-wire read-data pad is released when the core disables output
   a_r6_miso_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.three_wire && !spi_sdo_oe) |-> !miso_oe);
   // R7: shared data pad carries the core read data
   a_r7_sdat_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.three_wire && spi_sdo_oe) |-> (mosi_oe && (mosi_o == spi_sdo)));
   // R9: clock-out pad always follows its GPIO bit when driving both levels
   a_r9_xout_gpio: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.xout_od |-> (xout_oe && (xout_o == reg_rdata[7] || reg_addr != GPIO_ADDR)));
endmodule

// File: tb/spi_padmux_test.sv
`timescale 1ns/100ps
module spi_padmux_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
   logic       reg_we = 1'b0;
   logic [7:0] reg_rdata;
   logic       irq_req = 0, pactl_fn = 0, spi_sdo = 0, spi_sdo_oe = 0, spi_ss_n = 1;
   logic       spi_sdi;
   logic       irq_o, irq_oe, miso_o, miso_oe, xout_o, xout_oe;
   logic       pactl_o, pactl_oe, mosi_o, mosi_oe;
   logic       irq_i = 0, miso_i = 0, xout_i = 0, pactl_i = 0, mosi_i = 0;

   always #2.5 clk = ~clk;

   spi_padmux uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_req(irq_req),
      .pactl_fn(pactl_fn), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
      .spi_ss_n(spi_ss_n), .spi_sdi(spi_sdi),
      .irq_o(irq_o), .irq_oe(irq_oe), .irq_i(irq_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
      .xout_o(xout_o), .xout_oe(xout_oe), .xout_i(xout_i),
      .pactl_o(pactl_o), .pactl_oe(pactl_oe), .pactl_i(pactl_i),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i)
   );

   localparam logic [7:0] CFG = 8'h0D, GPIO = 8'h0E;
   localparam int P_IRQ = 10, P_MISO = 8, P_XOUT = 6, P_PACTL = 4, P_MOSI = 2;

   wire [18:0] obs = {reg_rdata, irq_o, irq_oe, miso_o, miso_oe, xout_o, xout_oe,
                      pactl_o, pactl_oe, mosi_o, mosi_oe, spi_sdi};

   typedef struct {
      string       tag;
      logic [18:0] exp;
      logic [18:0] mask;
   } item_t;

   item_t q[$];
   event  chk_ev;
   int    checks = 0, errors = 0;
   bit    done = 0;

   task automatic push(string tag, logic [18:0] exp, logic [18:0] mask);
      item_t it;
      it.tag = tag; it.exp = exp; it.mask = mask;
      q.push_back(it);
      -> chk_ev;
      #0.1;
   endtask

   task automatic exp_rd(string tag, logic [7:0] addr, logic [7:0] v);
      reg_addr = addr;
      #0.5;
      push(tag, {v, 11'b0}, {8'hFF, 11'b0});
   endtask

   task automatic exp_pad(string tag, int pos, logic o, logic oe);
      logic [18:0] e, m;
      e = '0; m = '0;
      m[pos-1] = 1'b1; e[pos-1] = oe;
      if (oe) begin m[pos] = 1'b1; e[pos] = o; end
      push(tag, e, m);
   endtask

   task automatic exp_sdi(string tag, logic v);
      push(tag, {18'b0, v}, 19'h1);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      #0.5;
   endtask

   task automatic step();
      @(negedge clk);
      #0.5;
   endtask

   // monitor: pops expected items and compares with the live outputs
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
               errors++;
               $display("FAIL %s actual %h expected %h", it.tag,
                        obs & it.mask, it.exp & it.mask);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R1 reset state
      exp_rd("R1 cfg reset", CFG, 8'h00);
      exp_rd("R1 gpio reset", GPIO, 8'h00);
      exp_pad("R1 irq idle high", P_IRQ, 1'b1, 1'b1);

      // R2 register port
      wr(CFG, 8'hA5);
      exp_rd("R2 cfg readback", CFG, 8'hA5);
      wr(GPIO, 8'hFF);
      exp_rd("R2 gpio low nibble read-only", GPIO, 8'hF0);
      wr(8'h10, 8'h33);
      exp_rd("R2 stray write ignored", CFG, 8'hA5);
      exp_rd("R2 stray address reads zero", 8'h10, 8'h00);
      wr(CFG, 8'h00);
      wr(GPIO, 8'h00);

      // R3 interrupt function and polarity
      irq_req = 1'b1; #0.5;
      exp_pad("R3 irq active low", P_IRQ, 1'b0, 1'b1);
      wr(CFG, 8'h40);
      exp_pad("R3 irq active high", P_IRQ, 1'b1, 1'b1);
      irq_req = 1'b0; #0.5;
      exp_pad("R3 irq high idle", P_IRQ, 1'b0, 1'b1);
      wr(CFG, 8'h80);
      irq_req = 1'b1; #0.5;
      exp_pad("R4 irq od pull low", P_IRQ, 1'b0, 1'b1);
      irq_req = 1'b0; #0.5;
      exp_pad("R4 irq od release", P_IRQ, 1'b0, 1'b0);

      // R9 / R4 clock-out pad
      wr(CFG, 8'h00);
      wr(GPIO, 8'h80);
      exp_pad("R9 xout drives 1", P_XOUT, 1'b1, 1'b1);
      wr(GPIO, 8'h00);
      exp_pad("R9 xout drives 0", P_XOUT, 1'b0, 1'b1);
      wr(CFG, 8'h10);
      wr(GPIO, 8'h80);
      exp_pad("R4 xout od release", P_XOUT, 1'b0, 1'b0);
      wr(GPIO, 8'h00);
      exp_pad("R4 xout od low", P_XOUT, 1'b0, 1'b1);

      // R8 / R11 amplifier control
      wr(CFG, 8'h00);
      pactl_fn = 1'b1; #0.5;
      exp_pad("R8 pactl function", P_PACTL, 1'b1, 1'b1);
      wr(GPIO, 8'h00);
      exp_pad("R11 pactl write no effect", P_PACTL, 1'b1, 1'b1);
      wr(CFG, 8'h04);
      exp_pad("R8 pactl gpio 0", P_PACTL, 1'b0, 1'b1);
      wr(GPIO, 8'h20);
      exp_pad("R8 pactl gpio 1", P_PACTL, 1'b1, 1'b1);
      pactl_fn = 1'b0;

      // R6 4-wire routing
      wr(CFG, 8'h00);
      wr(GPIO, 8'h40);
      spi_sdo = 1'b0; spi_sdo_oe = 1'b1; spi_ss_n = 1'b0; mosi_i = 1'b1; #0.5;
      exp_pad("R11 miso ignores gpio bit", P_MISO, 1'b0, 1'b1);
      spi_sdo = 1'b1; #0.5;
      exp_pad("R6 miso carries sdo", P_MISO, 1'b1, 1'b1);
      exp_pad("R6 mosi input only", P_MOSI, 1'b0, 1'b0);
      exp_sdi("R6 sdi from mosi pad", 1'b1);
      spi_sdo_oe = 1'b0; #0.5;
      exp_pad("R6 miso released", P_MISO, 1'b0, 1'b0);
      wr(CFG, 8'h20);
      spi_sdo_oe = 1'b1; #0.5;
      exp_pad("R6 miso od release on 1", P_MISO, 1'b0, 1'b0);
      spi_sdo = 1'b0; #0.5;
      exp_pad("R6 miso od pull low", P_MISO, 1'b0, 1'b1);
      mosi_i = 1'b0;

      // R7 3-wire routing
      wr(CFG, 8'h02);
      spi_sdo = 1'b1; spi_sdo_oe = 1'b1; #0.5;
      exp_pad("R7 sdat drives sdo", P_MOSI, 1'b1, 1'b1);
      exp_pad("R7 miso gpio 1", P_MISO, 1'b1, 1'b1);
      spi_sdo_oe = 1'b0; #0.5;
      exp_pad("R7 sdat released", P_MOSI, 1'b0, 1'b0);
      wr(GPIO, 8'h00);
      exp_pad("R7 miso gpio 0", P_MISO, 1'b0, 1'b1);

      // R5 interrupt rerouted to data-in pad
      spi_sdo = 1'b0;
      wr(CFG, 8'h41);
      irq_req = 1'b1; spi_ss_n = 1'b1; #0.5;
      exp_pad("R5 irq on mosi when idle", P_MOSI, 1'b1, 1'b1);
      exp_pad("R5 irq pad gpio 0", P_IRQ, 1'b0, 1'b1);
      spi_ss_n = 1'b0; #0.5;
      exp_pad("R5 mosi quiet when selected", P_MOSI, 1'b0, 1'b0);
      wr(GPIO, 8'h10);
      exp_pad("R5 irq pad gpio 1", P_IRQ, 1'b1, 1'b1);
      irq_req = 1'b0; spi_ss_n = 1'b1;

      // R10 input synchronizer
      wr(CFG, 8'h00);
      wr(GPIO, 8'h00);
      @(negedge clk);
      xout_i = 1'b1; miso_i = 1'b1; pactl_i = 1'b0; irq_i = 1'b1;
      exp_rd("R10 no change before edge", GPIO, 8'h00);
      step();
      exp_rd("R10 no change after one edge", GPIO, 8'h00);
      step();
      exp_rd("R10 visible after two edges", GPIO, 8'h0D);
      xout_i = 1'b0; miso_i = 1'b0; irq_i = 1'b0;
      step(); step(); step();
      exp_rd("R10 cleared", GPIO, 8'h00);

      done = 1;
      #1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule